// File: doc/BRIEF.md
# Bit-test conditional skip unit

This unit runs the two single-bit test instructions of a small 8-bit controller core. One tests a bit and skips the next instruction when that bit is clear. The other skips when the bit is set. The unit decodes a 16-bit instruction word and builds a 12-bit data-memory address from the 8-bit file operand and either a 4-bit bank register or a fixed access window. It reads one byte through a register-file port, picks the chosen bit, and then steps the program counter. When a skip is taken, it also discards the instruction that was prefetched.

The clock is the quarter-phase clock. Four clocks make one instruction cycle:

- Q1 decodes the instruction.
- Q2 reads the register file.
- Q3 evaluates the test.
- Q4 commits the result.

A skipped instruction is replaced by inserted no-op cycles. There is one such cycle for a one-word target and two for a two-word target. The unit reports these cycles as busy. The core feeds the unit the upper byte of the prefetched word, so the unit can tell how long the skipped instruction is.

Top module: `bitskip_unit`

## Requirements
- R1: An instruction is accepted only in Q1 (`q_phase`=0), with `issue` high and `busy` low, and only when bits [15:12] of the word are 1011 or 1010. Any other opcode causes no register read and leaves `pc` unchanged.
- R2: When bit 8 (the access flag) is 0, the bank register is ignored. File addresses 0x00–0x7F map to 0x000–0x07F, and 0x80–0xFF map to 0xF80–0xFFF.
- R3: When bit 8 is 1, the address is {bank register, bits [7:0]}.
- R4: Opcode 1011 skips when the bit selected by bits [11:9] of the read byte is 0.
- R5: Opcode 1010 skips when that selected bit is 1.
- R6: `q_phase` counts 0,1,2,3 and wraps. `rf_rd` is high only in Q2 of an accepted instruction, one clock after acceptance, with `rf_addr` valid at the same time.
- R7: Without a skip, `pc` advances by 1 at the end of Q4, `last_cycles` becomes 1 and `busy` stays low.
- R8: A skip over a one-word instruction raises `flush` during Q4 and advances `pc` by 2. `busy` is then high for exactly one instruction cycle (4 clocks), and `last_cycles` becomes 2.
- R9: A prefetched word whose upper byte has top nibble 0xC, or equals 0xEC or 0xEF, is two words long. Skipping it advances `pc` by 3, holds `busy` for two cycles (8 clocks), and sets `last_cycles` to 3.
- R10: While `busy` is high, `issue` is ignored: there is no read and no extra `pc` change.
- R11: During and right after reset, `pc` is RESET_PC (0), `q_phase`, `last_cycles`, `rf_rd`, `flush` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction word presented for execution |
| instr | input | 16 | Instruction word |
| bank_sel | input | 4 | Bank register value |
| prefetch_hi | input | 8 | Upper byte of the prefetched next word, valid by Q3 |
| rf_rdata | input | 8 | Register-file read data |
| rf_addr | output | 12 | Register-file read address |
| rf_rd | output | 1 | Register-file read strobe (Q2) |
| q_phase | output | 2 | Current quarter phase |
| pc | output | 16 | Program counter, in words |
| flush | output | 1 | Discard the prefetched instruction |
| busy | output | 1 | Inserted no-op cycle in progress |
| last_cycles | output | 2 | Cycle count of the last completed bit test |

## Verification
The assertions check these timing rules on every clock:

- reads happen only in Q2;
- a read follows one clock after acceptance;
- `flush` is high only in Q4;
- `busy` rises only after a flush;
- no read occurs while busy;
- `pc` moves only at a cycle boundary.

Other properties depend on the data, so only the bench scenarios can show them:

- which address each access-flag setting forms;
- the skip polarity for every bit index;
- the exact `pc` step;
- the busy length for one-word and two-word targets.

// File: rtl/bitskip_pkg.sv
package bitskip_pkg;
  localparam int BANK_W = 4;
  localparam int FILE_W = 8;
  localparam int ADDR_W = BANK_W + FILE_W;
  localparam int BIT_W  = $clog2(FILE_W);
  localparam int FLD_W  = 1 + BIT_W + 1 + FILE_W;  // polarity, index, access, file

  // only 101x is a bit test; bit 12 picks the polarity
  function automatic logic is_bit_test(input logic [15:0] w);
    return w[15:13] == 3'b101;
  endfunction

  function automatic logic [ADDR_W-1:0] form_addr(input logic use_bank,
                                                  input logic [BANK_W-1:0] bank,
                                                  input logic [FILE_W-1:0] f);
    if (use_bank) return {bank, f};
    return f[FILE_W-1] ? {{BANK_W{1'b1}}, f} : {{BANK_W{1'b0}}, f};
  endfunction

  // want_clear=1 : skip on a 0 bit; want_clear=0 : skip on a 1 bit
  function automatic logic skip_taken(input logic want_clear, input logic bit_v);
    return bit_v ^ want_clear;
  endfunction

  function automatic logic is_two_word(input logic [7:0] hi);
    return (hi[7:4] == 4'hC) || (hi == 8'hEC) || (hi == 8'hEF);
  endfunction

  // words the counter moves, which also equals the cycles spent
  function automatic logic [1:0] words_adv(input logic skip, input logic two);
    if (!skip) return 2'd1;
    return two ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/bitskip_decode.sv
module bitskip_decode
  import bitskip_pkg::*;
(
  input  logic [FLD_W-1:0]  fields,
  input  logic [BANK_W-1:0] bank,
  output logic              want_clear,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [ADDR_W-1:0] addr
);
  logic              use_bank;
  logic [FILE_W-1:0] file_op;

  always_comb begin
    want_clear = fields[FLD_W-1];
    bit_idx    = fields[FLD_W-2 -: BIT_W];
    use_bank   = fields[FILE_W];
    file_op    = fields[FILE_W-1:0];
    addr       = form_addr(use_bank, bank, file_op);
  end
endmodule

// File: rtl/bitskip_wordlen.sv
module bitskip_wordlen
  import bitskip_pkg::*;
(
  input  logic [7:0] next_hi,
  output logic       two_word
);
  assign two_word = is_two_word(next_hi);
endmodule

// File: rtl/bitskip_seq.sv
module bitskip_seq
  import bitskip_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            bit_val,
  input  logic            want_clear,
  input  logic            two_word,
  output logic [1:0]      ph,
  output logic            rd_now,
  output logic            flush,
  output logic            busy,
  output logic [PC_W-1:0] pc_q,
  output logic [1:0]      last_q
);
  logic       act_q, bit_q, skip_q, two_q;
  logic [1:0] nop_left;
  logic [1:0] adv;

  assign adv    = words_adv(skip_q, two_q);
  assign busy   = nop_left != 2'd0;
  assign rd_now = act_q && (ph == 2'd1);
  assign flush  = act_q && (ph == 2'd3) && skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= 2'd0;
      act_q    <= 1'b0;
      bit_q    <= 1'b0;
      skip_q   <= 1'b0;
      two_q    <= 1'b0;
      nop_left <= 2'd0;
      last_q   <= 2'd0;
      pc_q     <= PC_W'(RESET_PC);
    end else begin
      ph <= ph + 2'd1;
      case (ph)
        2'd0: if (accept) begin
          act_q  <= 1'b1;
          skip_q <= 1'b0;
          two_q  <= 1'b0;
        end
        2'd1: if (act_q) bit_q <= bit_val;
        2'd2: if (act_q) begin
          skip_q <= skip_taken(want_clear, bit_q);
          two_q  <= two_word;
        end
        default: begin
          if (act_q) begin
            act_q    <= 1'b0;
            pc_q     <= pc_q + PC_W'(adv);
            last_q   <= adv;
            nop_left <= adv - 2'd1;
          end else if (busy) begin
            nop_left <= nop_left - 2'd1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bitskip_unit.sv
module bitskip_unit
  import bitskip_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [15:0]       instr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [7:0]        prefetch_hi,
  input  logic [FILE_W-1:0] rf_rdata,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_rd,
  output logic [1:0]        q_phase,
  output logic [PC_W-1:0]   pc,
  output logic              flush,
  output logic              busy,
  output logic [1:0]        last_cycles
);
  logic [FLD_W-1:0]  fields_q;
  logic [BANK_W-1:0] bank_q;
  logic              accept_w;
  logic              want_clear;
  logic [BIT_W-1:0]  bit_idx;
  logic              bit_pick;
  logic              two_word;

  assign accept_w = issue && !busy && (q_phase == 2'd0) && is_bit_test(instr);
  assign bit_pick = rf_rdata[bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
      bank_q   <= '0;
    end else if (accept_w) begin
      fields_q <= instr[FLD_W-1:0];
      bank_q   <= bank_sel;
    end
  end

  bitskip_decode u_dec (
    .fields(fields_q), .bank(bank_q),
    .want_clear(want_clear), .bit_idx(bit_idx), .addr(rf_addr)
  );

  bitskip_wordlen u_len (.next_hi(prefetch_hi), .two_word(two_word));

  bitskip_seq #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .bit_val(bit_pick),
    .want_clear(want_clear), .two_word(two_word), .ph(q_phase),
    .rd_now(rf_rd), .flush(flush), .busy(busy), .pc_q(pc), .last_q(last_cycles)
  );
endmodule

// File: rtl/bitskip_chk.sv
module bitskip_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept_w,
  input logic            rf_rd,
  input logic [1:0]      q_phase,
  input logic            flush,
  input logic            busy,
  input logic [PC_W-1:0] pc
);
  p_read_in_q2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |-> q_phase == 2'd1);

  p_read_follows_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> rf_rd);

  p_flush_in_q4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> q_phase == 2'd3);

  p_busy_after_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(flush));

  p_no_read_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rf_rd);

  p_pc_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> q_phase == 2'd0);
endmodule

bind bitskip_unit bitskip_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_w(accept_w), .rf_rd(rf_rd),
  .q_phase(q_phase), .flush(flush), .busy(busy), .pc(pc)
);

// File: tb/sim_bitskip_unit.sv
`timescale 1ns/1ps
module sim_bitskip_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bank_sel = '0;
  logic [7:0]  prefetch_hi = '0;
  logic [7:0]  rf_rdata = '0;
  logic [11:0] rf_addr;
  logic        rf_rd, flush, busy;
  logic [1:0]  q_phase, last_cycles;
  logic [15:0] pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bitskip_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .bank_sel(bank_sel),
    .prefetch_hi(prefetch_hi), .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_rd(rf_rd),
    .q_phase(q_phase), .pc(pc), .flush(flush), .busy(busy), .last_cycles(last_cycles)
  );

  // fields: instr, bank, prefetch upper byte, read byte, address, skip, two-word
  localparam int VW = 16 + 4 + 8 + 8 + 12 + 1 + 1;
  localparam logic [VW-1:0] VEC [8] = '{
    {16'hB725, 4'h2, 8'h0F, 8'h00, 12'h225, 1'b1, 1'b0},
    {16'hA725, 4'h2, 8'hEF, 8'h08, 12'h225, 1'b1, 1'b1},
    {16'hBE90, 4'h5, 8'hC3, 8'h80, 12'hF90, 1'b0, 1'b0},
    {16'hA010, 4'hA, 8'h00, 8'hFE, 12'h010, 1'b0, 1'b0},
    {16'hB07F, 4'hF, 8'hC0, 8'hFE, 12'h07F, 1'b1, 1'b1},
    {16'hABFF, 4'hF, 8'hEC, 8'h20, 12'hFFF, 1'b1, 1'b1},
    {16'hAA80, 4'h3, 8'hED, 8'h20, 12'hF80, 1'b1, 1'b0},
    {16'hB500, 4'h0, 8'hE0, 8'hFB, 12'h000, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle_q1();
    @(negedge clk);
    while (!(q_phase == 2'd0 && !busy)) @(negedge clk);
  endtask

  task automatic run_one(input logic [15:0] w, input logic [3:0] b, input logic [7:0] pre,
                         input logic [7:0] data, input logic [11:0] ea,
                         input bit es, input bit et);
    logic [15:0] pc0;
    int adv;
    string areq, sreq, preq;
    adv  = !es ? 1 : (et ? 3 : 2);
    areq = w[8] ? "R3" : "R2";
    sreq = w[12] ? "R4" : "R5";
    preq = !es ? "R7" : (et ? "R9" : "R8");
    wait_idle_q1();
    pc0 = pc;
    issue = 1'b1; instr = w; bank_sel = b; prefetch_hi = pre; rf_rdata = data;
    @(negedge clk);                       // Q2
    issue = 1'b0;
    chk(rf_rd == 1'b1, "R6 read strobe", int'(rf_rd), 1);
    chk(rf_addr == ea, areq, int'(rf_addr), int'(ea));
    @(negedge clk);                       // Q3
    @(negedge clk);                       // Q4
    chk(flush == es, sreq, int'(flush), int'(es));
    @(negedge clk);                       // next Q1
    chk(pc == pc0 + 16'(adv), preq, int'(pc), int'(pc0 + 16'(adv)));
    chk(last_cycles == 2'(adv), preq, int'(last_cycles), adv);
    chk(busy == es, preq, int'(busy), int'(es));
    repeat ((adv - 1) * 4) @(negedge clk);
    chk(busy == 1'b0, preq, int'(busy), 0);
  endtask

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(pc == 16'h0 && q_phase == 2'd0 && !busy && !flush && !rf_rd && last_cycles == 2'd0,
        "R11 in reset", int'(pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == 16'h0 && !busy && !flush && !rf_rd && last_cycles == 2'd0,
        "R11 after reset", int'(pc), 0);
    chk(q_phase == 2'd1, "R6 phase count", int'(q_phase), 1);

    // vector table
    foreach (VEC[i]) begin
      run_one(VEC[i][49:34], VEC[i][33:30], VEC[i][29:22], VEC[i][21:14],
              VEC[i][13:2], VEC[i][1], VEC[i][0]);
    end

    // every bit index, both opcodes, bit set and clear
    for (int bi = 0; bi < 8; bi++) begin
      for (int op = 0; op < 2; op++) begin
        for (int v = 0; v < 2; v++) begin
          logic [7:0] msk;
          msk = 8'(1 << bi);
          run_one({3'b101, op[0], bi[2:0], 1'b1, 8'h42}, 4'h1, 8'h00,
                  v[0] ? msk : ~msk, 12'h142, op[0] ? !v[0] : v[0], 1'b0);
        end
      end
    end

    // R1 foreign opcode ignored
    begin
      logic [15:0] pc0;
      wait_idle_q1();
      pc0 = pc;
      issue = 1'b1; instr = 16'h9725; rf_rdata = 8'h00;
      @(negedge clk);
      issue = 1'b0;
      chk(rf_rd == 1'b0, "R1 no read", int'(rf_rd), 0);
      repeat (4) @(negedge clk);
      chk(pc == pc0, "R1 pc held", int'(pc), int'(pc0));
    end

    // R10 issue while busy is ignored
    begin
      logic [15:0] pc0;
      wait_idle_q1();
      pc0 = pc;
      issue = 1'b1; instr = 16'hB725; bank_sel = 4'h2; prefetch_hi = 8'hEF; rf_rdata = 8'h00;
      @(negedge clk);
      issue = 1'b0;
      repeat (3) @(negedge clk);          // next Q1, busy now
      chk(busy == 1'b1, "R10 busy", int'(busy), 1);
      issue = 1'b1; instr = 16'hA725; rf_rdata = 8'h08;
      @(negedge clk);
      issue = 1'b0;
      chk(rf_rd == 1'b0, "R10 no read", int'(rf_rd), 0);
      repeat (7) @(negedge clk);
      chk(pc == pc0 + 16'd3 && !busy, "R10 pc", int'(pc), int'(pc0 + 16'd3));
      repeat (8) @(negedge clk);
      chk(pc == pc0 + 16'd3, "R10 pc held", int'(pc), int'(pc0 + 16'd3));
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule